// File: doc/BRIEF.md
# Output Flag Trigger and Channel-ID Inserter

This block produces the five side-band flag bits that travel next to each output pixel sample. Every flag slot has its own source. It can be off. It can mark the one programmed pixel of each line. It can follow a timing pulse picked from the pulse bus. It can carry one chosen bit of a 3-bit code that names the input channel the sample came from. Software can therefore place any bit of the channel code in any flag slot. It can also leave trigger marks in some slots and put identity bits in the others.

Samples enter on a valid/ready stream that carries the pixel index and the channel index. The flag word leaves on a valid/ready stream after exactly one register stage, which matches the latency of the data path. A sample is accepted on a clock edge where `in_valid` and `in_ready` are both high. `in_ready` is high whenever the output register is empty or is being emptied in the same cycle. While `out_valid` is high and `out_ready` is low, the output word holds still and no new sample is taken. The configuration inputs are plain levels and are sampled together with each accepted sample.

Top module: `flag_inserter`

## Requirements
- R1: After reset, `out_valid` is 0, `flags` is 0 and `in_ready` is 1.
- R2: A slot k whose source field `slot_src[2k+1:2k]` is 0 outputs 0.
- R3: Source 1 outputs 1 exactly when the accepted `pix_idx` equals `trig_pix`.
- R4: Source 2 outputs `pulse_bus[pulse_sel]` as it was at acceptance.
- R5: Source 3 outputs bit `slot_pick[2k+1:2k]` (0, 1 or 2) of the channel code. A pick value of 3 outputs 0.
- R6: The channel code is `chan_idx + 1` for `chan_idx` 0 to 5 (001 to 110). It is 000 for `chan_idx` 6 and 7. For example, with code bit 2 in slot 1, bit 1 in slot 2 and bit 0 in slot 3, channel index 0 gives slot 1 = 0, slot 2 = 0 and slot 3 = 1.
- R7: The flag word of an accepted sample appears on `flags` with `out_valid` high on the cycle after acceptance. `out_valid` falls after a transfer when no new sample is accepted.
- R8: While `out_valid` is high and `out_ready` is low, `in_ready` is low and `flags` stays unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input sample valid |
| in_ready | output | 1 | Input sample accepted when high with in_valid |
| pix_idx | input | PIX_W (12) | Pixel position within the line |
| chan_idx | input | CH_W (3) | Input channel of the sample, 0 to 5 |
| pulse_bus | input | NUM_PULSE (8) | Generated timing pulses |
| trig_pix | input | PIX_W (12) | Pixel that the pixel trigger marks |
| pulse_sel | input | PSEL_W (3) | Pulse that the pulse trigger follows |
| slot_src | input | 2*NUM_SLOTS (10) | Per-slot source: 0 off, 1 pixel, 2 pulse, 3 ID bit |
| slot_pick | input | 2*NUM_SLOTS (10) | Per-slot ID bit index |
| out_valid | output | 1 | Flag word valid |
| out_ready | input | 1 | Downstream accepts the flag word |
| flags | output | NUM_SLOTS (5) | Flag word, bit k is slot k |

## Verification
The bench sweeps every channel index, including the two unused codes, against every pick value applied to all slots. A design that encoded the channel without the +1 offset, or that let pick 3 through, would show wrong bits here. Pixel and pulse triggers are swept across the match point and across every pulse line with one-hot and inverse patterns, which exposes an off-by-one compare or a wrong bus index. A stall is held with a second sample waiting, and the bench then releases the stall. A stage that overwrote a stalled word, or that dropped the waiting sample at release, would fail the stability or handoff checks.

// File: rtl/flag_pkg.sv
package flag_pkg;
  localparam int ID_W = 3;

  typedef enum logic [1:0] {
    SRC_OFF   = 2'd0,
    SRC_PIX   = 2'd1,
    SRC_PULSE = 2'd2,
    SRC_ID    = 2'd3
  } src_e;
endpackage

// File: rtl/flag_id_encode.sv
module flag_id_encode #(
  parameter int NUM_CHAN = 6,
  parameter int CH_W     = 3
) (
  input  logic [CH_W-1:0]           chan,
  output logic [flag_pkg::ID_W-1:0] code
);
  localparam int IW = flag_pkg::ID_W;
  localparam logic [CH_W:0] NCH = (CH_W+1)'(NUM_CHAN);

  logic chan_ok;

  always_comb begin
    chan_ok = ({1'b0, chan} < NCH);
    code    = chan_ok ? (IW'(chan) + IW'(1)) : '0;
  end

  // R6: a channel in range never yields the empty code
  always_comb begin
    if (chan_ok) p_code_nonzero_r6: assert (code != '0);
  end
endmodule

// File: rtl/flag_trig_detect.sv
module flag_trig_detect #(
  parameter int PIX_W     = 12,
  parameter int NUM_PULSE = 8,
  parameter int PSEL_W    = 3
) (
  input  logic [PIX_W-1:0]     pix_idx,
  input  logic [PIX_W-1:0]     trig_pix,
  input  logic [NUM_PULSE-1:0] pulse_bus,
  input  logic [PSEL_W-1:0]    pulse_sel,
  output logic                 pix_hit,
  output logic                 pulse_hit
);
  localparam logic [PSEL_W:0] NP = (PSEL_W+1)'(NUM_PULSE);

  always_comb begin
    pix_hit   = (pix_idx == trig_pix);
    pulse_hit = ({1'b0, pulse_sel} < NP) ? pulse_bus[pulse_sel] : 1'b0;
  end
endmodule

// File: rtl/flag_slot_mux.sv
module flag_slot_mux (
  input  logic                      pix_hit,
  input  logic                      pulse_hit,
  input  logic [flag_pkg::ID_W-1:0] code,
  input  logic [1:0]                src,
  input  logic [1:0]                pick,
  output logic                      bit_out
);
  import flag_pkg::*;

  logic id_bit;

  always_comb begin
    case (pick)
      2'd0:    id_bit = code[0];
      2'd1:    id_bit = code[1];
      2'd2:    id_bit = code[2];
      default: id_bit = 1'b0;
    endcase
    case (src_e'(src))
      SRC_PIX:   bit_out = pix_hit;
      SRC_PULSE: bit_out = pulse_hit;
      SRC_ID:    bit_out = id_bit;
      default:   bit_out = 1'b0;
    endcase
  end
endmodule

// File: rtl/flag_out_stage.sv
module flag_out_stage #(
  parameter int W = 5
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] d_flags,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] q_flags
);
  logic take;

  always_comb begin
    in_ready = !out_valid || out_ready;
    take     = in_valid && in_ready;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      q_flags   <= '0;
    end else begin
      if (take) begin
        out_valid <= 1'b1;
        q_flags   <= d_flags;
      end else if (out_ready) begin
        out_valid <= 1'b0;
      end
    end
  end

  // R7: accepted word shows up one cycle later
  p_load_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> (out_valid && q_flags == $past(d_flags)));

  // R7: valid drops after a transfer with nothing new
  p_drop_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready && !in_valid) |=> !out_valid);

  // R8: stalled word is held
  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(q_flags)));
endmodule

// File: rtl/flag_inserter.sv
module flag_inserter #(
  parameter int PIX_W     = 12,
  parameter int NUM_PULSE = 8,
  parameter int NUM_CHAN  = 6,
  parameter int NUM_SLOTS = 5,
  parameter int CH_W      = 3,
  parameter int PSEL_W    = $clog2(NUM_PULSE)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   in_valid,
  output logic                   in_ready,
  input  logic [PIX_W-1:0]       pix_idx,
  input  logic [CH_W-1:0]        chan_idx,
  input  logic [NUM_PULSE-1:0]   pulse_bus,
  input  logic [PIX_W-1:0]       trig_pix,
  input  logic [PSEL_W-1:0]      pulse_sel,
  input  logic [2*NUM_SLOTS-1:0] slot_src,
  input  logic [2*NUM_SLOTS-1:0] slot_pick,
  output logic                   out_valid,
  input  logic                   out_ready,
  output logic [NUM_SLOTS-1:0]   flags
);
  localparam int IW = flag_pkg::ID_W;

  logic [IW-1:0]        code;
  logic                 pix_hit;
  logic                 pulse_hit;
  logic [NUM_SLOTS-1:0] next_flags;

  flag_id_encode #(.NUM_CHAN(NUM_CHAN), .CH_W(CH_W)) u_enc (
    .chan (chan_idx),
    .code (code)
  );

  flag_trig_detect #(.PIX_W(PIX_W), .NUM_PULSE(NUM_PULSE), .PSEL_W(PSEL_W)) u_trig (
    .pix_idx   (pix_idx),
    .trig_pix  (trig_pix),
    .pulse_bus (pulse_bus),
    .pulse_sel (pulse_sel),
    .pix_hit   (pix_hit),
    .pulse_hit (pulse_hit)
  );

  for (genvar k = 0; k < NUM_SLOTS; k++) begin : g_slot
    flag_slot_mux u_mux (
      .pix_hit   (pix_hit),
      .pulse_hit (pulse_hit),
      .code      (code),
      .src       (slot_src[2*k +: 2]),
      .pick      (slot_pick[2*k +: 2]),
      .bit_out   (next_flags[k])
    );
  end

  flag_out_stage #(.W(NUM_SLOTS)) u_out (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .d_flags   (next_flags),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .q_flags   (flags)
  );

  // R2: all slots off gives an empty word
  p_all_off_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && slot_src == '0) |=> (flags == '0));
endmodule

// File: tb/flag_inserter_tb.sv
module flag_inserter_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [11:0] pix_idx = '0;
  logic [2:0]  chan_idx = '0;
  logic [7:0]  pulse_bus = '0;
  logic [11:0] trig_pix = '0;
  logic [2:0]  pulse_sel = '0;
  logic [9:0]  slot_src = '0;
  logic [9:0]  slot_pick = '0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [4:0]  flags;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  flag_inserter u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .pix_idx(pix_idx), .chan_idx(chan_idx), .pulse_bus(pulse_bus),
    .trig_pix(trig_pix), .pulse_sel(pulse_sel), .slot_src(slot_src),
    .slot_pick(slot_pick), .out_valid(out_valid), .out_ready(out_ready),
    .flags(flags)
  );

  function automatic logic [4:0] expect_flags();
    logic [4:0] r;
    logic [2:0] c;
    c = (chan_idx < 3'd6) ? chan_idx + 3'd1 : 3'd0;
    for (int k = 0; k < 5; k++) begin
      case (slot_src[2*k +: 2])
        2'd1:    r[k] = (pix_idx == trig_pix);
        2'd2:    r[k] = pulse_bus[pulse_sel];
        2'd3:    r[k] = (slot_pick[2*k +: 2] == 2'd3) ? 1'b0 : c[slot_pick[2*k +: 2]];
        default: r[k] = 1'b0;
      endcase
    end
    return r;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic send(input string req);
    logic [4:0] e;
    @(negedge clk);
    e = expect_flags();
    in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check({req, " valid"}, 32'(out_valid), 32'd1);
    check(req, 32'(flags), 32'(e));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] seed;
    logic [4:0]  held;
    seed = 32'h1234_5678;
    repeat (3) @(negedge clk);
    check("R1 out_valid", 32'(out_valid), 32'd0);
    check("R1 flags", 32'(flags), 32'd0);
    check("R1 in_ready", 32'(in_ready), 32'd1);
    rst_n = 1'b1;

    // R2: all slots off, any stimulus
    slot_src = '0; pulse_bus = 8'hFF; pix_idx = 12'd7; trig_pix = 12'd7;
    send("R2 off");

    // R5/R6: every channel against every pick value on all slots
    slot_src = 10'b11_11_11_11_11;
    for (int ch = 0; ch < 8; ch++) begin
      for (int p = 0; p < 4; p++) begin
        chan_idx = 3'(ch);
        slot_pick = {5{2'(p)}};
        send("R5 R6 id sweep");
      end
    end

    // R6 example: bit2->slot1, bit1->slot2, bit0->slot3, first channel
    slot_pick = {2'd0, 2'd0, 2'd1, 2'd2, 2'd0};
    slot_src  = {2'd0, 2'd3, 2'd3, 2'd3, 2'd0};
    chan_idx  = 3'd0;
    @(negedge clk); in_valid = 1'b1; @(negedge clk); in_valid = 1'b0;
    check("R6 example", 32'(flags), 32'b01000);

    // R3: pixel trigger across the match point
    slot_src = 10'b01_01_01_01_01; trig_pix = 12'd5;
    for (int px = 0; px < 10; px++) begin
      pix_idx = 12'(px);
      send("R3 pixel");
    end
    trig_pix = 12'hFFF; pix_idx = 12'hFFF; send("R3 pixel top");

    // R4: pulse trigger, one-hot and inverted buses
    slot_src = 10'b10_10_10_10_10;
    for (int s = 0; s < 8; s++) begin
      for (int j = 0; j < 8; j++) begin
        pulse_sel = 3'(s);
        pulse_bus = 8'(1 << j);
        send("R4 pulse");
        pulse_bus = ~pulse_bus;
        send("R4 pulse inv");
      end
    end

    // mixed slots, pseudo-random inputs
    for (int n = 0; n < 60; n++) begin
      seed = seed * 32'd1103515245 + 32'd12345; slot_src  = seed[25:16];
      seed = seed * 32'd1103515245 + 32'd12345; slot_pick = seed[25:16];
      seed = seed * 32'd1103515245 + 32'd12345;
      chan_idx = seed[18:16]; pulse_sel = seed[22:20]; pix_idx = {9'd0, seed[26:24]};
      trig_pix = {9'd0, seed[29:27]};
      seed = seed * 32'd1103515245 + 32'd12345; pulse_bus = seed[23:16];
      send("R2 R3 R4 R5 mixed");
    end

    // R7: valid drops after transfer with idle input
    @(negedge clk);
    check("R7 drop", 32'(out_valid), 32'd0);

    // R8: stall, waiting sample, release
    slot_src = 10'b11_11_11_11_11; slot_pick = {2'd2, 2'd1, 2'd0, 2'd2, 2'd1};
    out_ready = 1'b0; chan_idx = 3'd2;
    held = expect_flags();
    send("R8 first");
    chan_idx = 3'd4;
    in_valid = 1'b1;
    #1;
    check("R8 in_ready low", 32'(in_ready), 32'd0);
    @(negedge clk);
    check("R8 held valid", 32'(out_valid), 32'd1);
    check("R8 held flags", 32'(flags), 32'(held));
    @(negedge clk);
    check("R8 still held", 32'(flags), 32'(held));
    out_ready = 1'b1;
    #1;
    check("R8 ready on release", 32'(in_ready), 32'd1);
    held = expect_flags();
    @(negedge clk);
    in_valid = 1'b0;
    check("R7 handoff valid", 32'(out_valid), 32'd1);
    check("R7 handoff flags", 32'(flags), 32'(held));
    @(negedge clk);
    check("R7 empty", 32'(out_valid), 32'd0);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule